// File: doc/BRIEF.md
# Four-Channel Sampling Converter Frame Controller

This block is the host side of a synchronous serial link to a four-channel, 12-bit sampling converter. Each conversion takes exactly one frame. The controller pulls an active-low select line low and produces 16 serial clock periods. On those clocks it shifts a 16-bit control word out, most significant bit first. On the same clocks it shifts the 16-bit result word in. When the frame ends it splits the result into a channel number, 12 data bits and a frame-error flag. It then presents them on a valid/ready output.

After reset the controller runs a fixed number of dummy frames by itself. These frames carry the write bit low, so the converter's control register is left untouched. The controller then waits a programmable power-up time before it runs any requested frame. Between any two frames it keeps the select line high for a programmable quiet time. Requests enter through a one-entry holding slot and are never lost. A request that arrives during a frame, during the quiet time or during power-up waits in the slot until the controller can start it. A new frame also waits while an earlier result has not been taken from the output.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While `adc_cs_n` is high, `adc_sclk` is high. Each frame holds `adc_cs_n` low for exactly 16 falling edges of `adc_sclk`. The first falling edge comes HALF_DIV clock cycles after `adc_cs_n` falls, and later falling edges come every 2*HALF_DIV cycles.
- R2: `adc_din` changes only when `adc_cs_n` falls or `adc_sclk` rises. `adc_dout` is sampled once per falling edge of `adc_sclk`. Both words travel most significant bit first.
- R3: For a requested frame the control word is {1, seq, 00, addr[1:0], PM_BITS[1:0], 000, coding, 0000}. Bit 15 is the write bit, bit 14 is seq, bits 11:10 are addr and bit 4 is coding.
- R4: The received word is decoded as follows: bit 15 is the leading bit, bit 14 is ignored, bits 13:12 give `out_chan` and bits 11:0 give `out_data`.
- R5: `out_err` equals the leading bit of the received word, so it is 1 exactly when that bit is not zero.
- R6: While `out_valid` is high and `out_ready` is low, the outputs stay unchanged. No new frame starts while `out_valid` is high.
- R7: Between the end of one frame and the start of the next, `adc_cs_n` stays high for at least QUIET_CYC clock cycles.
- R8: After reset, the first NUM_DUMMY frames send the word 16'h7FFF, which has the write bit low. These frames produce no output.
- R9: At least PWRUP_CYC clock cycles pass between the end of the last dummy frame and the start of the first requested frame.
- R10: Once a request is accepted, `req_ready` stays low until that request's frame starts. Every accepted request yields exactly one frame and one output, in the order accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Holding slot free |
| req_seq | input | 1 | Sequence bit for the control word |
| req_addr | input | 2 | Channel address for the control word |
| req_coding | input | 1 | Output coding bit for the control word |
| adc_cs_n | output | 1 | Active-low frame select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Control word bit to the converter |
| adc_dout | input | 1 | Result bit from the converter (three-state outside a frame) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result taken by the consumer |
| out_chan | output | 2 | Channel number from the result word |
| out_data | output | 12 | Conversion data |
| out_err | output | 1 | Leading bit of the result was not zero |

## Verification
The hardest cases to reach from the ports are a request that waits in the slot through power-up and quiet time, and a finished result that stalls the next frame. The bench issues its first request during the dummy frames. It then sends requests back to back, so that they land mid-frame or during the quiet gap. It also holds `out_ready` low for a long stretch while a request is pending, and checks that the select line stays high. A converter model in the bench returns random words and sets the leading bit on chosen frames, which drives the error path.

// File: rtl/adc_frame_pkg.sv
`timescale 1ns/1ps
package adc_frame_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CHAN_W     = 2;
  localparam int SAMPLE_W   = 12;
  localparam logic [FRAME_BITS-1:0] DUMMY_WORD = 16'h7FFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_QUIET,
    ST_PWRUP
  } seq_state_t;

  function automatic logic [FRAME_BITS-1:0] build_ctrl(
    input logic       wr,
    input logic       seq,
    input logic [1:0] addr,
    input logic [1:0] pm,
    input logic       coding
  );
    return {wr, seq, 2'b00, addr, pm, 3'b000, coding, 4'b0000};
  endfunction
endpackage

// File: rtl/adc_req_slot.sv
`timescale 1ns/1ps
module adc_req_slot
  import adc_frame_pkg::*;
#(
  parameter logic [1:0] PM_BITS = 2'b11
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_seq,
  input  logic [1:0]            req_addr,
  input  logic                  req_coding,
  input  logic                  take,
  output logic                  req_ready,
  output logic                  pend,
  output logic [FRAME_BITS-1:0] pend_word
);
  logic                  pend_q;
  logic [FRAME_BITS-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      word_q <= '0;
    end else if (req_valid && !pend_q) begin
      pend_q <= 1'b1;
      word_q <= build_ctrl(1'b1, req_seq, req_addr, PM_BITS, req_coding);
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

  assign req_ready = !pend_q;
  assign pend      = pend_q;
  assign pend_word = word_q;
endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adc_frame_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 13,
  parameter int PWRUP_CYC = 1250,
  parameter int NUM_DUMMY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic out_busy,
  output logic cs_n,
  output logic sclk,
  output logic start_dummy,
  output logic start_real,
  output logic sample,
  output logic shift,
  output logic done,
  output logic frame_dummy
);
  localparam int M1   = (HALF_DIV > QUIET_CYC) ? HALF_DIV : QUIET_CYC;
  localparam int CMAX = (M1 > PWRUP_CYC) ? M1 : PWRUP_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int DW   = $clog2(NUM_DUMMY + 2);
  localparam int BW   = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] HALF_LAST  = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_CYC - 1);
  localparam logic [CW-1:0] PWR_LAST   = CW'(PWRUP_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST   = BW'(FRAME_BITS - 1);

  seq_state_t    st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic [DW-1:0] dummy_left;
  logic          pwr_done;
  logic          half_end;

  always_comb begin
    half_end    = (cnt == HALF_LAST);
    start_dummy = (st == ST_IDLE) && (dummy_left != '0);
    start_real  = (st == ST_IDLE) && (dummy_left == '0) && pwr_done && pend && !out_busy;
    sample      = ((st == ST_LEAD) || (st == ST_HIGH)) && half_end;
    shift       = (st == ST_LOW) && half_end && (bit_idx != BIT_LAST);
    done        = (st == ST_LOW) && half_end && (bit_idx == BIT_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      bit_idx     <= '0;
      dummy_left  <= DW'(NUM_DUMMY);
      pwr_done    <= 1'b0;
      cs_n        <= 1'b1;
      sclk        <= 1'b1;
      frame_dummy <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_dummy || start_real) begin
            cs_n        <= 1'b0;
            cnt         <= '0;
            bit_idx     <= '0;
            frame_dummy <= start_dummy;
            st          <= ST_LEAD;
          end else if ((dummy_left == '0) && !pwr_done) begin
            cnt <= '0;
            st  <= ST_PWRUP;
          end
        end
        ST_LEAD, ST_HIGH: begin
          if (half_end) begin
            sclk <= 1'b0;
            cnt  <= '0;
            st   <= ST_LOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (half_end) begin
            sclk <= 1'b1;
            cnt  <= '0;
            if (done) begin
              cs_n <= 1'b1;
              st   <= ST_QUIET;
              if (frame_dummy) dummy_left <= dummy_left - 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              st      <= ST_HIGH;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_QUIET: begin
          if (cnt == QUIET_LAST) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PWRUP: begin
          if (cnt == PWR_LAST) begin
            cnt      <= '0;
            pwr_done <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_shifter.sv
`timescale 1ns/1ps
module adc_frame_shifter
  import adc_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                shift,
  input  logic                sample,
  input  logic                dout,
  output logic                din,
  output logic                rx_lead,
  output logic [CHAN_W-1:0]   rx_chan,
  output logic [SAMPLE_W-1:0] rx_data
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [FRAME_BITS-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '1;
    end else if (load) begin
      tx_q <= load_word;
    end else if (shift) begin
      tx_q <= {tx_q[FRAME_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (sample) begin
      rx_q <= {rx_q[FRAME_BITS-2:0], dout};
    end
  end

  assign din     = tx_q[FRAME_BITS-1];
  assign rx_lead = rx_q[FRAME_BITS-1];
  assign rx_chan = rx_q[SAMPLE_W+CHAN_W-1:SAMPLE_W];
  assign rx_data = rx_q[SAMPLE_W-1:0];
endmodule

// File: rtl/adc_result_reg.sv
`timescale 1ns/1ps
module adc_result_reg
  import adc_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                lead,
  input  logic [CHAN_W-1:0]   chan,
  input  logic [SAMPLE_W-1:0] data,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_chan  <= chan;
      out_data  <= data;
      out_err   <= lead;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
`timescale 1ns/1ps
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int         HALF_DIV  = 2,
  parameter int         QUIET_CYC = 13,
  parameter int         PWRUP_CYC = 1250,
  parameter int         NUM_DUMMY = 2,
  parameter logic [1:0] PM_BITS   = 2'b11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_seq,
  input  logic [1:0]          req_addr,
  input  logic                req_coding,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_din,
  input  logic                adc_dout,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_err
);
  logic                  pend;
  logic [FRAME_BITS-1:0] pend_word;
  logic                  start_dummy, start_real;
  logic                  sample, shift, done, frame_dummy;
  logic                  rx_lead;
  logic [CHAN_W-1:0]     rx_chan;
  logic [SAMPLE_W-1:0]   rx_data;
  logic [FRAME_BITS-1:0] load_word;

  assign load_word = start_dummy ? DUMMY_WORD : pend_word;

  adc_req_slot #(.PM_BITS(PM_BITS)) u_slot (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_seq(req_seq),
    .req_addr(req_addr), .req_coding(req_coding), .take(start_real),
    .req_ready(req_ready), .pend(pend), .pend_word(pend_word)
  );

  adc_frame_seq #(
    .HALF_DIV(HALF_DIV), .QUIET_CYC(QUIET_CYC),
    .PWRUP_CYC(PWRUP_CYC), .NUM_DUMMY(NUM_DUMMY)
  ) u_seq (
    .clk(clk), .rst(rst), .pend(pend), .out_busy(out_valid),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .start_dummy(start_dummy),
    .start_real(start_real), .sample(sample), .shift(shift),
    .done(done), .frame_dummy(frame_dummy)
  );

  adc_frame_shifter u_shift (
    .clk(clk), .rst(rst), .load(start_dummy | start_real), .load_word(load_word),
    .shift(shift), .sample(sample), .dout(adc_dout), .din(adc_din),
    .rx_lead(rx_lead), .rx_chan(rx_chan), .rx_data(rx_data)
  );

  adc_result_reg u_res (
    .clk(clk), .rst(rst), .load(done && !frame_dummy), .lead(rx_lead),
    .chan(rx_chan), .data(rx_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data),
    .out_err(out_err)
  );
endmodule

// File: rtl/adc_frame_ctrl_chk.sv
`timescale 1ns/1ps
module adc_frame_ctrl_chk #(
  parameter int QUIET_CYC = 13,
  parameter int NUM_DUMMY = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        sclk,
  input logic        din,
  input logic        req_valid,
  input logic        req_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [1:0]  out_chan,
  input logic [11:0] out_data,
  input logic        out_err
);
  int   qcnt;
  int   fcnt;
  int   frames_seen;
  logic sclk_prev;
  logic cs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt        <= QUIET_CYC;
      fcnt        <= 0;
      frames_seen <= 0;
      sclk_prev   <= 1'b1;
      cs_prev     <= 1'b1;
    end else begin
      sclk_prev <= sclk;
      cs_prev   <= cs_n;
      if (cs_n) qcnt <= (qcnt < QUIET_CYC + 4) ? qcnt + 1 : qcnt;
      else      qcnt <= 0;
      if (cs_n) fcnt <= 0;
      else if (sclk_prev && !sclk) fcnt <= fcnt + 1;
      if (cs_n && !cs_prev) frames_seen <= frames_seen + 1;
    end
  end

  // R1: serial clock idles high outside a frame
  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (rst) cs_n |-> sclk);
  // R1: sixteen serial clock falls per frame
  a_r1_sixteen: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |-> (fcnt == 16));
  // R2: data-in moves only with a rising serial clock or the start of a frame
  a_r2_din_edge: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$stable(din)) |-> ($rose(sclk) || $fell(cs_n)));
  // R7: quiet time before each frame
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> (qcnt >= QUIET_CYC));
  // R8: dummy frames start with the write bit low
  a_r8_dummy_nowrite: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && (frames_seen < NUM_DUMMY)) |-> !din);
  // R6: held result stays stable
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_err)));
  // R6: no frame starts while a result waits
  a_r6_no_start: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> !$past(out_valid));
  // R10: an accepted request occupies the slot
  a_r10_pending: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready);
endmodule

bind adc_frame_ctrl adc_frame_ctrl_chk #(.QUIET_CYC(QUIET_CYC), .NUM_DUMMY(NUM_DUMMY)) u_chk (
  .clk(clk), .rst(rst), .cs_n(adc_cs_n), .sclk(adc_sclk), .din(adc_din),
  .req_valid(req_valid), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_chan(out_chan), .out_data(out_data), .out_err(out_err)
);

// File: tb/test_adc_frame_ctrl.sv
`timescale 1ns/1ps
module test_adc_frame_ctrl;
  localparam int HALF_DIV  = 2;
  localparam int QUIET_CYC = 13;
  localparam int PWRUP_CYC = 1250;
  localparam int NUM_DUMMY = 2;
  localparam int NREQ      = 40;
  localparam int TCLK      = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_seq = 1'b0, req_coding = 1'b0;
  logic [1:0]  req_addr = 2'b00;
  logic        req_ready;
  logic        adc_cs_n, adc_sclk, adc_din;
  logic        adc_dout = 1'b1;
  logic        out_valid, out_err;
  logic        out_ready = 1'b0;
  logic [1:0]  out_chan;
  logic [11:0] out_data;

  adc_frame_ctrl #(
    .HALF_DIV(HALF_DIV), .QUIET_CYC(QUIET_CYC), .PWRUP_CYC(PWRUP_CYC),
    .NUM_DUMMY(NUM_DUMMY), .PM_BITS(2'b11)
  ) i_adc_frame_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_seq(req_seq), .req_addr(req_addr), .req_coding(req_coding),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_dout(adc_dout),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_data(out_data), .out_err(out_err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_ctrl(input logic s, input logic [1:0] a, input logic c);
    return {1'b1, s, 2'b00, a, 2'b11, 3'b000, c, 4'b0000};
  endfunction

  // converter model
  logic [15:0] res_words [0:63];
  logic [15:0] ctrl_seen [0:63];
  logic [15:0] m_tx, m_rx;
  int  nframes = 0;
  int  nstarts = 0;
  int  nfall = 0;
  bit  in_frame = 0;
  bit  tim_ok = 1;
  time t_cs_fall = 0, t_last_fall = 0, t_cs_rise = 0;

  always @(negedge adc_cs_n) begin
    if (nframes == NUM_DUMMY)
      chk(($time - t_cs_rise) >= PWRUP_CYC * TCLK, "R9 power-up gap", 32'($time - t_cs_rise), PWRUP_CYC * TCLK);
    else if (nframes > 0)
      chk(($time - t_cs_rise) >= QUIET_CYC * TCLK, "R7 quiet gap", 32'($time - t_cs_rise), QUIET_CYC * TCLK);
    m_tx      = res_words[nframes % 64];
    adc_dout  = m_tx[15];
    nfall     = 0;
    tim_ok    = 1;
    in_frame  = 1;
    t_cs_fall = $time;
    nstarts++;
  end

  always @(posedge adc_sclk) begin
    if (!adc_cs_n && nfall < 16) begin
      m_tx     = {m_tx[14:0], 1'b1};
      adc_dout = m_tx[15];
    end
  end

  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      if (nfall == 0) tim_ok &= (($time - t_cs_fall) == HALF_DIV * TCLK);
      else            tim_ok &= (($time - t_last_fall) == 2 * HALF_DIV * TCLK);
      t_last_fall = $time;
      m_rx = {m_rx[14:0], adc_din};
      nfall++;
    end
  end

  always @(posedge adc_cs_n) begin
    if (in_frame) begin
      chk(nfall == 16 && tim_ok, "R1 sclk count/timing", nfall, 16);
      ctrl_seen[nframes % 64] = m_rx;
      nframes++;
      t_cs_rise = $time;
      in_frame  = 0;
      adc_dout  = 1'b1;
    end
  end

  logic       e_seq [0:NREQ-1];
  logic [1:0] e_addr [0:NREQ-1];
  logic       e_cod [0:NREQ-1];
  int         n_out = 0;
  bit         timeout = 0;

  task automatic producer();
    for (int k = 0; k < NREQ; k++) begin
      if (k % 10 == 5) repeat (60) @(negedge clk);
      else repeat ($urandom % 3) @(negedge clk);
      e_seq[k]   = 1'($urandom);
      e_addr[k]  = 2'($urandom);
      e_cod[k]   = 1'($urandom);
      req_seq    = e_seq[k];
      req_addr   = e_addr[k];
      req_coding = e_cod[k];
      req_valid  = 1'b1;
      forever begin
        if (req_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R10 slot occupied", req_ready, 0);
    end
  endtask

  task automatic consumer();
    int s0;
    while (n_out < NREQ) begin
      @(negedge clk);
      if (n_out == 10 && out_valid) begin
        out_ready = 1'b0;
        s0 = nstarts;
        repeat (200) @(negedge clk);
        chk(adc_cs_n == 1'b1 && nstarts == s0, "R6 no frame while result held", nstarts, s0);
      end
      out_ready = (($urandom % 4) != 0);
      if (out_valid && out_ready) begin
        logic [15:0] w;
        w = res_words[NUM_DUMMY + n_out];
        chk(out_chan == w[13:12], "R4 channel", out_chan, w[13:12]);
        chk(out_data == w[11:0], "R4 data", out_data, w[11:0]);
        chk(out_err == w[15], "R5 frame error", out_err, w[15]);
        n_out++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) res_words[i] = {1'b0, 1'($urandom), 14'($urandom)};
    res_words[NUM_DUMMY + 3][15] = 1'b1;
    res_words[NUM_DUMMY + 7][15] = 1'b1;
    res_words[NUM_DUMMY + 12][14] = 1'b1;

    repeat (5) @(negedge clk);
    chk(adc_cs_n == 1'b1, "R1 reset cs_n", adc_cs_n, 1);
    chk(adc_sclk == 1'b1, "R1 reset sclk", adc_sclk, 1);
    chk(out_valid == 1'b0, "R6 reset out_valid", out_valid, 0);
    chk(req_ready == 1'b1, "R10 reset req_ready", req_ready, 1);
    rst = 1'b0;

    fork
      begin
        fork
          producer();
          consumer();
        join
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    repeat (5) @(negedge clk);

    chk(!timeout, "watchdog", 32'(timeout), 0);
    chk(nframes == NUM_DUMMY + NREQ, "R10 one frame per request", nframes, NUM_DUMMY + NREQ);
    chk(n_out == NREQ, "R8 no output from dummy frames", n_out, NREQ);
    chk(out_valid == 1'b0, "R10 no extra output", out_valid, 0);
    for (int i = 0; i < NUM_DUMMY; i++)
      chk(ctrl_seen[i] == 16'h7FFF, "R8 dummy word", ctrl_seen[i], 16'h7FFF);
    for (int k = 0; k < NREQ; k++)
      chk(ctrl_seen[NUM_DUMMY + k] == exp_ctrl(e_seq[k], e_addr[k], e_cod[k]),
          "R3 control word (R2 MSB first)", ctrl_seen[NUM_DUMMY + k], exp_ctrl(e_seq[k], e_addr[k], e_cod[k]));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule